// File: doc/BRIEF.md
# Register Window Decoder with Self-Identifying Module Slots

This block sits between a simple single-cycle register request bus and a group of on-chip modules. It claims a 2 MB address window starting at 0x1BE0_0000, splits it into 4 kB slots, and steers each access to the module that owns the addressed slot. Every populated slot answers a fixed identifier word at slot offset 0xFFC, so software can discover the module map by reading that offset in each slot. Slots with no module, and modules currently hidden, answer the fixed word 0xDEADABBA.

A protection module inside the window holds two ownership masks, one per peripheral bus group. Each stub module is tied to one group and one mask bit. While that bit is clear the module behaves as if absent. Modules are identifier stubs with two scratch registers each; the request is answered combinationally in the cycle it is presented, and writes take effect at the next rising clock edge.

Top module: `mmio_window_dec`

## Requirements
- R1: With req_valid high, an address from 0x1BE0_0000 to 0x1BFF_FFFF sets rsp_hit and rsp_ready in the same cycle; any other address, or req_valid low, gives rsp_hit=0, rsp_ready=0 and rsp_rdata=0.
- R2: A read at offset 0xFFC of a visible module slot returns {module ID[31:16], major[15:12], minor[11:8], size[7:0]}; the modules are at window offsets 0x40000 (0x0113_0100, group A bit 0), 0x42000 (0x010A_1000, group A bit 1), 0x61000 (0x0127_0000, group B bit 0) and 0x100000 (0x2B80_2001, group B bit 3).
- R3: The size field counts 4 kB units minus one; the module with size 1 answers in both slots 0x100000 and 0x101000 (its identifier at 0xFFC of each), and its scratch registers live only in its first slot.
- R4: A read at any offset of a slot with no module returns 0xDEADABBA.
- R5: Each module has two scratch registers at module offsets 0x000 and 0x004, reset to zero and read back as written; other non-identifier offsets read zero.
- R6: The protection module at window offset 0x4D000 holds the group A mask at +0x000 and the group B mask at +0x004 (both readable and writable), answers 0x0128_0000 at +0xFFC, and its masks reset to 0x0000_0003 and 0x0000_0001, so the module at 0x100000 is hidden after reset.
- R7: While a module's mask bit is clear, its reads return 0xDEADABBA and its writes are dropped.
- R8: Writes to an identifier offset or to an empty slot change nothing and still see rsp_ready high.
- R9: A mask write changes visibility from the very next access; writing all ones to both masks exposes every module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_ready | output | 1 | Request accepted this cycle |
| rsp_hit | output | 1 | Address lies inside the window |

## Verification
The ownership check and a module access fall in the same cycle: a write aimed at a hidden module's scratch register is evaluated against the mask in force in that very cycle and must be dropped. The bench provokes this by writing the hidden module's scratch, then opening its mask bit and reading the scratch back in the following access, expecting zero; it also reads a module immediately after the mask write that hides or reveals it, expecting the new visibility without a gap cycle.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  localparam int WIN_BITS  = 21;
  localparam int OFF_BITS  = 12;
  localparam int SLOT_W    = WIN_BITS - OFF_BITS;
  localparam int NUM_STUBS = 4;
  localparam logic [31:0] EMPTY_WORD = 32'hDEAD_ABBA;

  typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} grp_e;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [15:0]       mod_id;
    logic [3:0]        rev_major;
    logic [3:0]        rev_minor;
    logic [7:0]        size_m1;
    grp_e              grp;
    logic [4:0]        mask_bit;
  } stub_cfg_t;

  // Identifier word layout: id | major | minor | size-1
  function automatic logic [31:0] ident_word(stub_cfg_t c);
    return {c.mod_id, c.rev_major, c.rev_minor, c.size_m1};
  endfunction

  function automatic stub_cfg_t stub_cfg(int idx);
    stub_cfg_t c;
    case (idx)
      0:       c = '{slot: 9'h040, mod_id: 16'h0113, rev_major: 4'd0, rev_minor: 4'd1, size_m1: 8'd0, grp: GRP_A, mask_bit: 5'd0};
      1:       c = '{slot: 9'h042, mod_id: 16'h010A, rev_major: 4'd1, rev_minor: 4'd0, size_m1: 8'd0, grp: GRP_A, mask_bit: 5'd1};
      2:       c = '{slot: 9'h061, mod_id: 16'h0127, rev_major: 4'd0, rev_minor: 4'd0, size_m1: 8'd0, grp: GRP_B, mask_bit: 5'd0};
      default: c = '{slot: 9'h100, mod_id: 16'h2B80, rev_major: 4'd2, rev_minor: 4'd0, size_m1: 8'd1, grp: GRP_B, mask_bit: 5'd3};
    endcase
    return c;
  endfunction

  function automatic logic addr_in_window(logic [31:0] addr, logic [31:0] base);
    return (addr >> WIN_BITS) == (base >> WIN_BITS);
  endfunction
endpackage

// File: rtl/mmio_addr_split.sv
module mmio_addr_split
  import mmio_dec_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h1BE0_0000
) (
  input  logic                req_valid,
  input  logic [31:0]         req_addr,
  output logic                win_hit,
  output logic [SLOT_W-1:0]   slot,
  output logic [OFF_BITS-1:0] offset
);
  logic [WIN_BITS-1:0] rel;

  assign rel     = req_addr[WIN_BITS-1:0];
  assign win_hit = req_valid && addr_in_window(req_addr, WIN_BASE);
  assign slot    = rel[WIN_BITS-1:OFF_BITS];
  assign offset  = rel[OFF_BITS-1:0];
endmodule

// File: rtl/mmio_stub.sv
module mmio_stub
  import mmio_dec_pkg::*;
#(
  parameter stub_cfg_t CFG = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [OFF_BITS-1:0] offset,
  input  logic [31:0]         wdata,
  input  logic                owned,
  output logic                claim,
  output logic [31:0]         rdata
);
  localparam int          SPAN    = int'(CFG.size_m1) + 1;
  localparam logic [31:0] ID_WORD = ident_word(CFG);

  logic [31:0] scratch0, scratch1;
  logic        in_range, first_slot, wr0, wr1, hidden_write;

  assign in_range     = (int'(slot) >= int'(CFG.slot)) && (int'(slot) < int'(CFG.slot) + SPAN);
  assign first_slot   = (slot == CFG.slot);
  assign claim        = acc_valid && in_range && owned;
  assign wr0          = claim && acc_write && first_slot && (offset == 12'h000);
  assign wr1          = claim && acc_write && first_slot && (offset == 12'h004);
  assign hidden_write = acc_valid && acc_write && in_range && !owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch0 <= '0;
      scratch1 <= '0;
    end else begin
      if (wr0) scratch0 <= wdata;
      if (wr1) scratch1 <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (offset == 12'hFFC)                     rdata = ID_WORD;
    else if (first_slot && offset == 12'h000)  rdata = scratch0;
    else if (first_slot && offset == 12'h004)  rdata = scratch1;
  end

  // R7: a write to a hidden module leaves its scratch registers untouched
  a_r7_hidden_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_write |=> ($stable(scratch0) && $stable(scratch1)));
endmodule

// File: rtl/mmio_guard.sv
module mmio_guard
  import mmio_dec_pkg::*;
#(
  parameter logic [31:0] MASK_A_RST = 32'h0000_0003,
  parameter logic [31:0] MASK_B_RST = 32'h0000_0001,
  parameter logic [15:0] GUARD_ID   = 16'h0128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                acc_write,
  input  logic [OFF_BITS-1:0] offset,
  input  logic [31:0]         wdata,
  output logic [31:0]         mask_a,
  output logic [31:0]         mask_b,
  output logic [31:0]         rdata
);
  logic load_a, load_b;

  assign load_a = sel && acc_write && (offset == 12'h000);
  assign load_b = sel && acc_write && (offset == 12'h004);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a <= MASK_A_RST;
      mask_b <= MASK_B_RST;
    end else begin
      if (load_a) mask_a <= wdata;
      if (load_b) mask_b <= wdata;
    end
  end

  always_comb begin
    case (offset)
      12'h000: rdata = mask_a;
      12'h004: rdata = mask_b;
      12'hFFC: rdata = {GUARD_ID, 16'h0000};
      default: rdata = '0;
    endcase
  end

  // R6 / R9: a mask write is visible on the next cycle
  a_r6_mask_a_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_a |=> (mask_a == $past(wdata)));
  a_r6_mask_b_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> (mask_b == $past(wdata)));
endmodule

// File: rtl/mmio_window_dec.sv
module mmio_window_dec
  import mmio_dec_pkg::*;
#(
  parameter logic [31:0]       WIN_BASE   = 32'h1BE0_0000,
  parameter logic [SLOT_W-1:0] GUARD_SLOT = 9'h04D,
  parameter logic [31:0]       MASK_A_RST = 32'h0000_0003,
  parameter logic [31:0]       MASK_B_RST = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        rsp_ready,
  output logic        rsp_hit
);
  logic                 win_hit;
  logic [SLOT_W-1:0]    slot;
  logic [OFF_BITS-1:0]  offset;
  logic [31:0]          mask_a, mask_b, guard_rd;
  logic                 guard_sel;
  logic [NUM_STUBS-1:0] claim, owned;
  logic [31:0]          stub_rd [NUM_STUBS];

  mmio_addr_split #(.WIN_BASE(WIN_BASE)) i_split (
    .req_valid(req_valid), .req_addr(req_addr),
    .win_hit(win_hit), .slot(slot), .offset(offset)
  );

  assign guard_sel = win_hit && (slot == GUARD_SLOT);

  mmio_guard #(.MASK_A_RST(MASK_A_RST), .MASK_B_RST(MASK_B_RST)) i_guard (
    .clk(clk), .rst_n(rst_n), .sel(guard_sel), .acc_write(req_write),
    .offset(offset), .wdata(req_wdata),
    .mask_a(mask_a), .mask_b(mask_b), .rdata(guard_rd)
  );

  for (genvar g = 0; g < NUM_STUBS; g++) begin : g_stub
    localparam stub_cfg_t CFG = stub_cfg(g);
    assign owned[g] = (CFG.grp == GRP_A) ? mask_a[CFG.mask_bit] : mask_b[CFG.mask_bit];
    mmio_stub #(.CFG(CFG)) i_stub (
      .clk(clk), .rst_n(rst_n), .acc_valid(win_hit), .acc_write(req_write),
      .slot(slot), .offset(offset), .wdata(req_wdata), .owned(owned[g]),
      .claim(claim[g]), .rdata(stub_rd[g])
    );
  end

  always_comb begin
    rsp_rdata = '0;
    if (win_hit) begin
      if (|claim) begin
        for (int i = 0; i < NUM_STUBS; i++)
          if (claim[i]) rsp_rdata = rsp_rdata | stub_rd[i];
      end else if (guard_sel) begin
        rsp_rdata = guard_rd;
      end else begin
        rsp_rdata = EMPTY_WORD;
      end
    end
  end

  assign rsp_hit   = win_hit;
  assign rsp_ready = win_hit;

  // R1: an in-window request is accepted in its own cycle
  a_r1_ready_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_hit) |-> rsp_ready);
  // R1: unclaimed requests stay silent
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_rdata == 32'h0 && !rsp_ready));
  // R3: module apertures never overlap, even for multi-slot modules
  a_r3_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim));
  // R6: the guard slot is never claimed by a stub
  a_r6_guard_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    guard_sel |-> (claim == '0));
endmodule

// File: tb/test_mmio_window_dec.sv
module test_mmio_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_ready, rsp_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_a, m_b;
  logic [31:0] sc [4][2];

  always #4 clk = ~clk;

  mmio_window_dec i_mmio_window_dec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit)
  );

  localparam logic [31:0] BASE = 32'h1BE0_0000;

  function automatic int mod_at(int s);
    case (s)
      'h40: return 0;
      'h42: return 1;
      'h61: return 2;
      'h100, 'h101: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int base_slot(int m);
    int t [4] = '{'h40, 'h42, 'h61, 'h100};
    return t[m];
  endfunction

  function automatic logic [31:0] id_of(int m);
    logic [31:0] t [4] = '{32'h0113_0100, 32'h010A_1000, 32'h0127_0000, 32'h2B80_2001};
    return t[m];
  endfunction

  function automatic bit visible(int m);
    case (m)
      0: return m_a[0];
      1: return m_a[1];
      2: return m_b[0];
      default: return m_b[3];
    endcase
  endfunction

  function automatic bit inside_win(logic [31:0] a);
    return a >= BASE && a <= 32'h1BFF_FFFF;
  endfunction

  function automatic logic [31:0] ref_read(logic [31:0] a);
    logic [31:0] rel;
    int s, lo, m;
    if (!inside_win(a)) return 32'h0;
    rel = a - BASE;
    s = int'(rel >> 12);
    lo = int'(rel & 32'hFFF);
    if (s == 'h4D) begin
      if (lo == 0) return m_a;
      if (lo == 4) return m_b;
      if (lo == 'hFFC) return 32'h0128_0000;
      return 32'h0;
    end
    m = mod_at(s);
    if (m < 0 || !visible(m)) return 32'hDEAD_ABBA;
    if (lo == 'hFFC) return id_of(m);
    if (s == base_slot(m) && lo == 0) return sc[m][0];
    if (s == base_slot(m) && lo == 4) return sc[m][1];
    return 32'h0;
  endfunction

  task automatic ref_write(logic [31:0] a, logic [31:0] d);
    logic [31:0] rel;
    int s, lo, m;
    if (!inside_win(a)) return;
    rel = a - BASE;
    s = int'(rel >> 12);
    lo = int'(rel & 32'hFFF);
    if (s == 'h4D) begin
      if (lo == 0) m_a = d;
      if (lo == 4) m_b = d;
      return;
    end
    m = mod_at(s);
    if (m < 0 || !visible(m) || s != base_slot(m)) return;
    if (lo == 0) sc[m][0] = d;
    if (lo == 4) sc[m][1] = d;
  endtask

  // One bus cycle: drive after falling edge, compare before the rising edge
  task automatic access(bit v, bit w, logic [31:0] a, logic [31:0] d, string tag);
    logic [31:0] er;
    bit eh;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    #2;
    eh = v && inside_win(a);
    er = (v && !w) ? ref_read(a) : (eh ? ref_read(a) : 32'h0);
    checks++;
    if (rsp_hit !== eh || rsp_ready !== eh || (!w && rsp_rdata !== er) || (!eh && rsp_rdata !== 32'h0)) begin
      errors++;
      $display("FAIL %s addr=%h w=%0d: got rdata=%h hit=%b ready=%b, expected rdata=%h hit=%b ready=%b",
               tag, a, w, rsp_rdata, rsp_hit, rsp_ready, er, eh, eh);
    end
    @(posedge clk);
    if (v && w) ref_write(a, d);
  endtask

  task automatic rd(logic [31:0] a, string tag);
    access(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, string tag);
    access(1'b1, 1'b1, a, d, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_a = 32'h0000_0003;
    m_b = 32'h0000_0001;
    for (int i = 0; i < 4; i++) begin sc[i][0] = '0; sc[i][1] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R6 reset masks, R10-like reset of scratch under R5
    rd(BASE + 32'h4D000, "R6");
    rd(BASE + 32'h4D004, "R6");
    rd(BASE + 32'h4DFFC, "R6");
    rd(BASE + 32'h40000, "R5");
    rd(BASE + 32'h100FFC, "R7");   // hidden after reset

    // R1 window edges and idle
    rd(32'h1BDF_FFFC, "R1");
    rd(32'h1C00_0000, "R1");
    rd(32'h0000_0FFC, "R1");
    access(1'b0, 1'b0, BASE + 32'h40FFC, 32'h0, "R1");
    wr(32'h1C00_0000, 32'h1234_5678, "R1");

    // R4 empty slots
    rd(BASE, "R4");
    rd(32'h1BFF_FFFC, "R4");
    rd(BASE + 32'h41ABC, "R4");

    // R2 identifier words
    rd(BASE + 32'h40FFC, "R2");
    rd(BASE + 32'h42FFC, "R2");
    rd(BASE + 32'h61FFC, "R2");
    for (int s = 'h3C; s < 'h64; s++) rd(BASE + (s << 12) + 32'hFFC, "R2");

    // R5 scratch
    wr(BASE + 32'h40000, 32'hA5A5_0001, "R5");
    wr(BASE + 32'h40004, 32'h5A5A_0002, "R5");
    rd(BASE + 32'h40000, "R5");
    rd(BASE + 32'h40004, "R5");
    rd(BASE + 32'h40008, "R5");
    wr(BASE + 32'h61004, 32'hCAFE_F00D, "R5");
    rd(BASE + 32'h61004, "R5");

    // R8 dropped writes
    wr(BASE + 32'h42FFC, 32'hFFFF_FFFF, "R8");
    rd(BASE + 32'h42FFC, "R8");
    wr(BASE + 32'h50000, 32'h1111_1111, "R8");
    rd(BASE + 32'h50000, "R8");

    // R7 write to hidden module, then open it (R9 next cycle)
    wr(BASE + 32'h100000, 32'hBAD0_BAD0, "R7");
    wr(BASE + 32'h4D004, 32'hFFFF_FFFF, "R9");
    rd(BASE + 32'h100FFC, "R9");
    rd(BASE + 32'h100000, "R7");

    // R3 two-slot module
    rd(BASE + 32'h101FFC, "R3");
    wr(BASE + 32'h100004, 32'h0BAD_CAFE, "R3");
    rd(BASE + 32'h100004, "R3");
    rd(BASE + 32'h101004, "R3");
    rd(BASE + 32'h102FFC, "R3");

    // R7 hide a module on group A, check immediately (R9)
    wr(BASE + 32'h4D000, 32'h0000_0001, "R9");
    rd(BASE + 32'h42FFC, "R7");
    wr(BASE + 32'h42000, 32'h7777_7777, "R7");
    rd(BASE + 32'h40FFC, "R7");
    wr(BASE + 32'h4D000, 32'hFFFF_FFFF, "R9");
    rd(BASE + 32'h42000, "R7");
    rd(BASE + 32'h42FFC, "R9");
    rd(BASE + 32'h4D000, "R6");

    // R7 hide a group B module while it holds data
    wr(BASE + 32'h4D004, 32'h0000_0008, "R9");
    rd(BASE + 32'h61004, "R7");
    wr(BASE + 32'h4D004, 32'h0000_0009, "R9");
    rd(BASE + 32'h61004, "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule